// File: doc/BRIEF.md
# Packed Color Palette Memory

This block is the color lookup table of a display pipeline. It holds 256 color entries. A register bus sees them as 128 words of 32 bits, so each bus word carries two entries. Software fills the table through the bus and can read each word back unchanged. The pixel path presents an 8-bit index and receives a 24-bit RGB color one cycle later.

Each 16-bit entry holds three 5-bit channels and an intensity flag. The flag is kept in storage but plays no part in the color. On lookup, the selected entry is split into its channels. Each channel is widened to 8 bits by appending three zero bits below it.

The bus port takes a byte offset. Only the window from 0x200 to 0x3FC belongs to the palette. Offsets outside that window are ignored for writes and read back as zero.

Top module: `palette_ram`

## Requirements
- R1: Reset is synchronous and active low. After reset, `lk_valid` and `bus_rvalid` are low. Every word reads back as zero, and every index looks up to RGB zero.
- R2: A write with byte offset 0x200 + 4n stores the 32-bit data in word n, for n from 0 to 127. A read of the same offset returns that exact word, intensity bits included, on `bus_rdata` one cycle later. `bus_rvalid` goes high in that same cycle.
- R3: Index 2n selects bits [15:0] of word n. Index 2n+1 selects bits [31:16] of word n.
- R4: Within an entry, red is bits [4:0], green is bits [9:5] and blue is bits [14:10]. The output `lk_rgb` is {red, green, blue}, with red in [23:16]. Each output channel is the 5-bit field shifted left by 3.
- R5: The intensity bit of an entry (bit 15 of the entry) has no effect on `lk_rgb`.
- R6: `lk_valid` is high exactly in the cycle after `lk_req` was high. `lk_rgb` changes only in that cycle and otherwise holds its value.
- R7: When a bus write and a lookup address the same entry in the same cycle, the lookup returns the color from before the write. Lookups in later cycles return the new color.
- R8: The two low bits of the bus offset are ignored. A write outside 0x200 to 0x3FF changes no word. A read outside that window returns zero, with `bus_rvalid` still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_addr | input | 12 | Bus byte offset |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after `bus_rd` |
| lk_req | input | 1 | Lookup request |
| lk_index | input | 8 | Palette index to look up |
| lk_rgb | output | 24 | Registered color {red, green, blue} |
| lk_valid | output | 1 | Color valid, one cycle after `lk_req` |

## Verification
The assertions check the following on every cycle:
- the one-cycle timing of both valid signals;
- that the lookup color holds between requests;
- that a write in the window lands in the addressed word;
- that out-of-window reads return zero.

Only the bench scenarios can show the rest:
- the exact data, half-word and channel placement;
- that the intensity bit is ignored;
- the old-value result of a same-cycle write and lookup.

To cover these, the bench sweeps every word and every index against values it computes itself.

// File: rtl/pal_pkg.sv
// Package: shared types for the palette memory.
// Assumes the entry layout is 1 flag bit over three 5-bit channels.
package pal_pkg;
    localparam int CH_W     = 5;
    localparam int OUT_CH_W = 8;
    localparam int WORD_W   = 32;

    // Color fields of one entry; the intensity bit is not carried here
    typedef struct packed {
        logic [CH_W-1:0] blue;
        logic [CH_W-1:0] green;
        logic [CH_W-1:0] red;
    } pal_color_t;

    // Widened output color
    typedef struct packed {
        logic [OUT_CH_W-1:0] r;
        logic [OUT_CH_W-1:0] g;
        logic [OUT_CH_W-1:0] b;
    } pal_rgb_t;
endpackage

// File: rtl/pal_addr_decode.sv
// Module: pal_addr_decode
// Maps a bus byte offset to a word index and a window-hit flag.
// Assumes the window starts at BASE and spans 4*WORDS bytes; the low two
// offset bits do not affect the index.
module pal_addr_decode #(
    parameter int            AW    = 12,
    parameter int            WORDS = 128,
    parameter logic [AW-1:0] BASE  = 12'h200,
    localparam int           IDX_W = $clog2(WORDS)
) (
    input  logic [AW-1:0]    addr,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    localparam logic [AW:0] SPAN = (AW+1)'(WORDS * 4);

    logic [AW-1:0] offs;

    // Offset relative to the window base
    assign offs = addr - BASE;
    // Inside the window when above the base and below the span
    assign hit = (addr >= BASE) && ({1'b0, offs} < SPAN);
    // Word index drops the byte-lane bits
    assign idx = offs[IDX_W+1:2];
endmodule

// File: rtl/pal_store.sv
// Module: pal_store
// Word storage with one bus write port, one registered bus read port and
// one combinational lookup read that returns the selected half-word colors.
// Assumes all reads observe contents from before a same-cycle write.
module pal_store
    import pal_pkg::*;
#(
    parameter int  WORDS = 128,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              rd_hit,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid,
    input  logic [IDX_W-1:0]  lk_idx,
    input  logic              lk_half,
    output pal_color_t        lk_color
);
    logic [WORD_W-1:0] mem [WORDS];
    logic [WORD_W-1:0] lk_word;

    // Storage update: clear everything on reset, else take the bus write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    // Registered bus read; out-of-window reads return zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_data <= rd_hit ? mem[rd_idx] : '0;
        end
    end

    // Lookup read: pick the word, then the half that holds the entry
    assign lk_word  = mem[lk_idx];
    assign lk_color = lk_half ? pal_color_t'(lk_word[30:16])
                              : pal_color_t'(lk_word[14:0]);

    // R2: an accepted write lands in the addressed word
    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> mem[$past(wr_idx)] == $past(wr_data));

    // R2: read data is valid the cycle after a read strobe
    assert_rd_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    // R8: reads outside the window return zero
    assert_outside_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_hit) |=> rd_data == '0);
endmodule

// File: rtl/pal_unpack.sv
// Module: pal_unpack
// Widens the three 5-bit channels of an entry to 8 bits and registers the
// result together with a valid flag.
// Assumes the color input is settled in the cycle the request is high.
module pal_unpack
    import pal_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  pal_color_t color,
    output pal_rgb_t   rgb,
    output logic       valid
);
    localparam int PAD = OUT_CH_W - CH_W;

    pal_rgb_t wide;

    // Channel widening by appending zero bits below each field
    always_comb begin
        wide.r = {color.red,   {PAD{1'b0}}};
        wide.g = {color.green, {PAD{1'b0}}};
        wide.b = {color.blue,  {PAD{1'b0}}};
    end

    // Output register: load on request, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rgb   <= '0;
            valid <= 1'b0;
        end else begin
            valid <= req;
            if (req) rgb <= wide;
        end
    end

    // R6: valid follows a request by one cycle
    assert_valid_after_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> valid);

    // R6: no valid without a request one cycle earlier
    assert_no_spurious_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !valid);

    // R6: color holds when no request was made
    assert_rgb_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> $stable(rgb));
endmodule

// File: rtl/palette_ram.sv
// Module: palette_ram
// Palette of 2*WORDS color entries. The bus sees them packed two per word.
// The lookup port turns an index into a registered 24-bit color.
// Assumes single-cycle bus strobes and that read and write do not share a cycle.
module palette_ram
    import pal_pkg::*;
#(
    parameter int            AW    = 12,
    parameter int            WORDS = 128,
    parameter logic [AW-1:0] BASE  = 12'h200,
    localparam int           IDX_W = $clog2(WORDS),
    localparam int           LK_W  = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [AW-1:0]     bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    input  logic              lk_req,
    input  logic [LK_W-1:0]   lk_index,
    output logic [23:0]       lk_rgb,
    output logic              lk_valid
);
    logic             win_hit;
    logic [IDX_W-1:0] win_idx;
    pal_color_t       sel_color;
    pal_rgb_t         rgb_q;

    // Bus offset decode
    pal_addr_decode #(.AW(AW), .WORDS(WORDS), .BASE(BASE)) u_dec (
        .addr (bus_addr),
        .hit  (win_hit),
        .idx  (win_idx)
    );

    // Packed word storage
    pal_store #(.WORDS(WORDS)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr && win_hit),
        .wr_idx   (win_idx),
        .wr_data  (bus_wdata),
        .rd_en    (bus_rd),
        .rd_hit   (win_hit),
        .rd_idx   (win_idx),
        .rd_data  (bus_rdata),
        .rd_valid (bus_rvalid),
        .lk_idx   (lk_index[LK_W-1:1]),
        .lk_half  (lk_index[0]),
        .lk_color (sel_color)
    );

    // Channel widening and output register
    pal_unpack u_unpack (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (lk_req),
        .color (sel_color),
        .rgb   (rgb_q),
        .valid (lk_valid)
    );

    assign lk_rgb = rgb_q;

    // R8: out-of-window writes never reach storage (guarded at the decode)
    assert_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr < BASE)) |-> !win_hit);
endmodule

// File: tb/sim_palette_ram.sv
`timescale 1ns/1ps
module sim_palette_ram;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        lk_req = 1'b0;
    logic [7:0]  lk_index = '0;
    logic [23:0] lk_rgb;
    logic        lk_valid;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;
    int cycles   = 0;
    logic [31:0] model [128];

    always #2 clk = ~clk;

    palette_ram u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .lk_req(lk_req), .lk_index(lk_index),
        .lk_rgb(lk_rgb), .lk_valid(lk_valid)
    );

    function automatic logic [31:0] pattern(int n);
        return (32'(n) * 32'h0107_3A59) ^ 32'hC3A5_5A3C;
    endfunction

    // Expected color: pick the half-word, take the 5-bit fields, shift left by 3
    function automatic logic [23:0] color_of(logic [31:0] w, int idx);
        logic [15:0] e;
        e = idx[0] ? w[31:16] : w[15:0];
        return {e[4:0], 3'b000, e[9:5], 3'b000, e[14:10], 3'b000};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
            summary();
        end
    end

    // Tasks start at a negedge; results are sampled at the next negedge
    task automatic bus_write(logic [11:0] a, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(string tag, logic [11:0] a, logic [31:0] exp);
        bus_rd = 1'b1; bus_addr = a;
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b0;
        check({tag, " rvalid"}, 32'(bus_rvalid), 32'd1);
        check(tag, bus_rdata, exp);
    endtask

    task automatic lookup(string tag, int idx, logic [23:0] exp);
        lk_req = 1'b1; lk_index = 8'(idx);
        @(posedge clk); @(negedge clk);
        lk_req = 1'b0;
        check({tag, " valid"}, 32'(lk_valid), 32'd1);
        check(tag, 32'(lk_rgb), 32'(exp));
    endtask

    initial begin
        logic [23:0] held;
        logic [31:0] nw;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 lk_valid after reset", 32'(lk_valid), 0);
        check("R1 rvalid after reset", 32'(bus_rvalid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        lookup("R1 lookup idx0", 0, 24'h0);
        lookup("R1 lookup idx255", 255, 24'h0);
        bus_read("R1 read word0", 12'h200, 32'h0);
        bus_read("R1 read word127", 12'h3FC, 32'h0);

        // R2: fill every word, then read every word back
        for (int n = 0; n < 128; n++) begin
            model[n] = pattern(n);
            bus_write(12'(12'h200 + 4*n), model[n]);
        end
        for (int n = 0; n < 128; n++) bus_read("R2 readback", 12'(12'h200 + 4*n), model[n]);

        // R3/R4: every index against the computed color
        for (int i = 0; i < 256; i++) lookup("R3 R4 lookup sweep", i, color_of(model[i/2], i));

        // R6: no request -> valid low and color held
        held = lk_rgb;
        @(posedge clk); @(negedge clk);
        check("R6 valid low without request", 32'(lk_valid), 0);
        check("R6 color held", 32'(lk_rgb), 32'(held));

        // R5: flipping only the intensity bits leaves colors unchanged
        nw = model[5] ^ 32'h8000_8000;
        bus_write(12'h214, nw);
        bus_read("R5 raw word keeps intensity", 12'h214, nw);
        lookup("R5 intensity ignored low", 10, color_of(model[5], 10));
        lookup("R5 intensity ignored high", 11, color_of(model[5], 11));
        model[5] = nw;

        // R7: same-cycle write and lookup of entry 14 (word 7, low half)
        nw = ~model[7];
        bus_wr = 1'b1; bus_addr = 12'h21C; bus_wdata = nw;
        lk_req = 1'b1; lk_index = 8'd14;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0; lk_req = 1'b0;
        check("R7 lookup sees old color", 32'(lk_rgb), 32'(color_of(model[7], 14)));
        model[7] = nw;
        lookup("R7 next lookup sees new color", 14, color_of(model[7], 14));

        // R8: out-of-window writes ignored, reads return zero, low bits ignored
        bus_write(12'h1FC, 32'hDEAD_BEEF);
        bus_write(12'h400, 32'hFEED_F00D);
        bus_read("R8 word0 unchanged", 12'h200, model[0]);
        bus_read("R8 word127 unchanged", 12'h3FC, model[127]);
        bus_read("R8 read below window", 12'h1FC, 32'h0);
        bus_read("R8 read above window", 12'h400, 32'h0);
        bus_write(12'h203, 32'h1234_5678);
        model[0] = 32'h1234_5678;
        bus_read("R8 unaligned write hits word0", 12'h202, model[0]);
        lookup("R8 unaligned write color", 1, color_of(model[0], 1));

        if (!finished) begin
            finished = 1'b1;
            summary();
        end
    end
endmodule